// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block is the digital divider pair of a frequency synthesizer. On the feedback side, a dual-modulus prescaler counts oscillator ticks and divides by either P or P+1. A swallow counter A keeps the prescaler in its P+1 modulus for the first A prescaler cycles of each output period. A main counter N then closes the period after N prescaler cycles in total. The feedback ratio is therefore P·N + A ticks for each comparison pulse `fp_pulse`. On the reference side, a 14-bit counter divides reference ticks by R and emits `fr_pulse`.

Both tick inputs are clock enables on the common system clock. New settings arrive through two load strobes. Out-of-range values are repaired and reported, then held pending until the current period ends, so a period is never cut short. A power-save input freezes both dividers where they stand. Settings may still be loaded while the dividers are frozen.

Top module: `psw_divider`

## Requirements
- R1: With a tick on every clock cycle, consecutive `fp_pulse` events are exactly P·N + A cycles apart. Each `fp_pulse` lasts a single clock cycle.
- R2: `cfg_sw` = 1 selects the smaller prescaler pair and `cfg_sw` = 0 selects the larger pair. For the default low-band variant (RF_SIDE = 0) these are 16/17 and 32/33. For RF_SIDE = 1 they are 64/65 and 128/129.
- R3: Within each period, `dual_hi` is high while the prescaler uses P+1. It rises together with `fp_pulse` and stays high for exactly A·(P+1) cycles of the period.
- R4: With a reference tick on every cycle, consecutive `fr_pulse` events are exactly R cycles apart. Each `fr_pulse` lasts a single cycle.
- R5: A feedback load (`ld_fb`) does not change the period in progress. The new N, A and SW values govern the period that starts at the next `fp_pulse`.
- R6: A reference load (`ld_ref`) does not change the reference period in progress. The new R governs the period that starts at the next `fr_pulse`.
- R7: A loaded N below 5, or a loaded R below 5, is replaced by 5. In that case `ratio_clamped` is high in the cycle after the load. A load with legal values, and any cycle without a load, leaves `ratio_clamped` low in the next cycle.
- R8: A loaded A that is not below the (repaired) N is replaced by N−1, and `ratio_clamped` is high in the cycle after the load.
- R9: While `save` is high, neither divider advances and no pulse is produced. Counting resumes from the same point afterwards, so a period is lengthened by exactly the number of save cycles. Loads made during save are accepted.
- R10: During reset all outputs are low. After reset the ratios are N = 8, A = 0, SW = 1 and R = 10, so the first `fp_pulse` arrives 128 cycles and the first `fr_pulse` 10 cycles after reset is released.
- R11: Only cycles with `vco_tick` high advance the feedback divider. With a tick on every second cycle, the `fp_pulse` spacing doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vco_tick | input | 1 | One oscillator cycle to be counted by the feedback divider |
| ref_tick | input | 1 | One reference cycle to be counted by the reference divider |
| save | input | 1 | Power-save hold; freezes both dividers |
| ld_fb | input | 1 | Load strobe for `cfg_sw`, `cfg_n`, `cfg_a` |
| cfg_sw | input | 1 | Prescaler pair select (1 = smaller pair) |
| cfg_n | input | 11 | Main counter ratio N |
| cfg_a | input | 7 | Swallow count A |
| ld_ref | input | 1 | Load strobe for `cfg_r` |
| cfg_r | input | 14 | Reference ratio R |
| fp_pulse | output | 1 | Single-cycle feedback comparison pulse |
| fr_pulse | output | 1 | Single-cycle reference pulse |
| dual_hi | output | 1 | Prescaler currently dividing by P+1 |
| ratio_clamped | output | 1 | A loaded value was repaired in the previous cycle |

## Verification
The terminal tick and the pulse register share a clock edge, so a pulse becomes visible one edge after the tick that completes its period. The repair flag likewise appears one edge after its load strobe. The bench drives inputs and samples outputs on falling edges. It counts falling edges from one pulse to the next, so a measured spacing equals the ratio in ticks, plus any save cycles, with no offset. The `dual_hi` count runs from the sample where a pulse is seen up to the sample before the next pulse. Each load is placed on the first cycle after a pulse, so the bench expects the old ratio for that interval and the new ratio for the one after it.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int N_W       = 11;
    localparam int A_W       = 7;
    localparam int R_W       = 14;
    localparam int RATIO_MIN = 5;

    typedef struct packed {
        logic           sw;
        logic [A_W-1:0] a;
        logic [N_W-1:0] n;
    } fb_cfg_t;

    function automatic logic [N_W-1:0] n_fix(input logic [N_W-1:0] n);
        return (n < N_W'(RATIO_MIN)) ? N_W'(RATIO_MIN) : n;
    endfunction

    function automatic fb_cfg_t fb_fix(input logic sw,
                                       input logic [N_W-1:0] n,
                                       input logic [A_W-1:0] a);
        fb_cfg_t        c;
        logic [N_W-1:0] nn;
        logic [N_W-1:0] aw;
        nn   = n_fix(n);
        aw   = {{(N_W-A_W){1'b0}}, a};
        c.sw = sw;
        c.n  = nn;
        c.a  = (aw >= nn) ? A_W'(nn - N_W'(1)) : a;
        return c;
    endfunction

    function automatic logic fb_bad(input logic [N_W-1:0] n,
                                    input logic [A_W-1:0] a);
        logic [N_W-1:0] aw;
        aw = {{(N_W-A_W){1'b0}}, a};
        return (n < N_W'(RATIO_MIN)) || (aw >= n_fix(n));
    endfunction

    function automatic logic [R_W-1:0] r_fix(input logic [R_W-1:0] r);
        return (r < R_W'(RATIO_MIN)) ? R_W'(RATIO_MIN) : r;
    endfunction

endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler
    import psw_pkg::*;
#(
    parameter int RF_SIDE = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic sw,
    input  logic plus1,
    output logic wrap
);
    localparam int P_SW1 = (RF_SIDE != 0) ? 64 : 16;
    localparam int P_SW0 = 2 * P_SW1;
    localparam int CW    = $clog2(P_SW0 + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        last = sw ? CW'(P_SW1 - 1) : CW'(P_SW0 - 1);
        if (plus1) last = last + CW'(1);
    end

    assign wrap = step && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step) begin
            if (cnt == last) cnt <= '0;
            else             cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/psw_swallow.sv
module psw_swallow
    import psw_pkg::*;
#(
    parameter int RST_N  = 8,
    parameter int RST_A  = 0,
    parameter int RST_SW = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pre_wrap,
    input  logic    ld,
    input  fb_cfg_t ld_cfg,
    output logic    fp,
    output logic    plus1,
    output logic    sw_act
);
    fb_cfg_t        act;
    fb_cfg_t        pend;
    fb_cfg_t        nxt;
    logic           pend_v;
    logic [N_W-1:0] n_left;
    logic [A_W-1:0] a_left;
    logic           term;

    assign term   = pre_wrap && (n_left == N_W'(1));
    assign nxt    = pend_v ? pend : act;
    assign plus1  = (a_left != '0);
    assign sw_act = act.sw;

    always_ff @(posedge clk) begin
        if (rst) begin
            act.sw <= 1'(RST_SW);
            act.n  <= N_W'(RST_N);
            act.a  <= A_W'(RST_A);
            pend   <= '0;
            pend_v <= 1'b0;
            n_left <= N_W'(RST_N);
            a_left <= A_W'(RST_A);
            fp     <= 1'b0;
        end else begin
            if (ld) begin
                pend   <= ld_cfg;
                pend_v <= 1'b1;
            end else if (term) begin
                pend_v <= 1'b0;
            end
            if (term) begin
                act    <= nxt;
                n_left <= nxt.n;
                a_left <= nxt.a;
            end else if (pre_wrap) begin
                n_left <= n_left - N_W'(1);
                if (a_left != '0) a_left <= a_left - A_W'(1);
            end
            fp <= term;
        end
    end
endmodule

// File: rtl/psw_refdiv.sv
module psw_refdiv
    import psw_pkg::*;
#(
    parameter int RST_R = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    input  logic           ld,
    input  logic [R_W-1:0] ld_r,
    output logic           fr
);
    logic [R_W-1:0] r_act;
    logic [R_W-1:0] r_pend;
    logic           pend_v;
    logic [R_W-1:0] r_left;
    logic [R_W-1:0] r_nxt;
    logic           term;

    assign term  = step && (r_left == R_W'(1));
    assign r_nxt = pend_v ? r_pend : r_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_act  <= R_W'(RST_R);
            r_pend <= '0;
            pend_v <= 1'b0;
            r_left <= R_W'(RST_R);
            fr     <= 1'b0;
        end else begin
            if (ld) begin
                r_pend <= ld_r;
                pend_v <= 1'b1;
            end else if (term) begin
                pend_v <= 1'b0;
            end
            if (term) begin
                r_act  <= r_nxt;
                r_left <= r_nxt;
            end else if (step) begin
                r_left <= r_left - R_W'(1);
            end
            fr <= term;
        end
    end
endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psw_pkg::*;
#(
    parameter int RF_SIDE = 0,
    parameter int RST_N   = 8,
    parameter int RST_A   = 0,
    parameter int RST_SW  = 1,
    parameter int RST_R   = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           vco_tick,
    input  logic           ref_tick,
    input  logic           save,
    input  logic           ld_fb,
    input  logic           cfg_sw,
    input  logic [N_W-1:0] cfg_n,
    input  logic [A_W-1:0] cfg_a,
    input  logic           ld_ref,
    input  logic [R_W-1:0] cfg_r,
    output logic           fp_pulse,
    output logic           fr_pulse,
    output logic           dual_hi,
    output logic           ratio_clamped
);
    logic    fb_step;
    logic    ref_step;
    logic    pre_wrap;
    logic    sw_act;
    fb_cfg_t fb_new;
    logic    fb_rep;
    logic    r_rep;

    assign fb_step  = vco_tick && !save;
    assign ref_step = ref_tick && !save;
    assign fb_new   = fb_fix(cfg_sw, cfg_n, cfg_a);
    assign fb_rep   = fb_bad(cfg_n, cfg_a);
    assign r_rep    = (cfg_r < R_W'(RATIO_MIN));

    always_ff @(posedge clk) begin
        if (rst) ratio_clamped <= 1'b0;
        else     ratio_clamped <= (ld_fb && fb_rep) || (ld_ref && r_rep);
    end

    psw_prescaler #(.RF_SIDE(RF_SIDE)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .step  (fb_step),
        .sw    (sw_act),
        .plus1 (dual_hi),
        .wrap  (pre_wrap)
    );

    psw_swallow #(.RST_N(RST_N), .RST_A(RST_A), .RST_SW(RST_SW)) u_swl (
        .clk      (clk),
        .rst      (rst),
        .pre_wrap (pre_wrap),
        .ld       (ld_fb),
        .ld_cfg   (fb_new),
        .fp       (fp_pulse),
        .plus1    (dual_hi),
        .sw_act   (sw_act)
    );

    psw_refdiv #(.RST_R(RST_R)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .step (ref_step),
        .ld   (ld_ref),
        .ld_r (r_fix(cfg_r)),
        .fr   (fr_pulse)
    );
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk
    import psw_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           save,
    input logic           ld_fb,
    input logic           ld_ref,
    input logic [N_W-1:0] cfg_n,
    input logic [A_W-1:0] cfg_a,
    input logic [R_W-1:0] cfg_r,
    input logic           fp_pulse,
    input logic           fr_pulse,
    input logic           dual_hi,
    input logic           ratio_clamped
);
    logic [N_W-1:0] a_wide;
    assign a_wide = {{(N_W-A_W){1'b0}}, cfg_a};

    AST_FP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fp_pulse |=> !fp_pulse); // R1
    AST_FR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fr_pulse |=> !fr_pulse); // R4
    AST_PLUS1_START: assert property (@(posedge clk) disable iff (rst)
        $rose(dual_hi) |-> fp_pulse); // R3
    AST_CLAMP_N: assert property (@(posedge clk) disable iff (rst)
        (ld_fb && cfg_n < N_W'(RATIO_MIN)) |=> ratio_clamped); // R7
    AST_CLAMP_R: assert property (@(posedge clk) disable iff (rst)
        (ld_ref && cfg_r < R_W'(RATIO_MIN)) |=> ratio_clamped); // R7
    AST_QUIET_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!ld_fb && !ld_ref) |=> !ratio_clamped); // R7
    AST_CLAMP_A: assert property (@(posedge clk) disable iff (rst)
        (ld_fb && cfg_n >= N_W'(RATIO_MIN) && a_wide >= cfg_n) |=> ratio_clamped); // R8
    AST_SAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        save |=> (!fp_pulse && !fr_pulse)); // R9
    AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        save |=> $stable(dual_hi)); // R9
    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (!fp_pulse && !fr_pulse && !ratio_clamped)); // R10
endmodule

bind psw_divider psw_divider_chk u_chk (.*);

// File: tb/psw_divider_tb.sv
`timescale 1ns/1ps
module psw_divider_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vco_tick = 1'b1;
    logic        ref_tick = 1'b1;
    logic        save = 1'b0;
    logic        ld_fb = 1'b0;
    logic        cfg_sw = 1'b1;
    logic [10:0] cfg_n = '0;
    logic [6:0]  cfg_a = '0;
    logic        ld_ref = 1'b0;
    logic [13:0] cfg_r = '0;
    logic        fp_pulse, fr_pulse, dual_hi, ratio_clamped;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    localparam int WD = 20000;

    always #4 clk = ~clk;

    psw_divider u_dut (
        .clk(clk), .rst(rst), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .save(save), .ld_fb(ld_fb), .cfg_sw(cfg_sw), .cfg_n(cfg_n),
        .cfg_a(cfg_a), .ld_ref(ld_ref), .cfg_r(cfg_r),
        .fp_pulse(fp_pulse), .fr_pulse(fr_pulse), .dual_hi(dual_hi),
        .ratio_clamped(ratio_clamped)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One feedback period, starting at the sample where fp_pulse was seen.
    task automatic run_fp(input bit do_ld, input bit sw, input int n, input int a,
                          input int ss, input int sl, input int div,
                          output int len, output int dual, output int flag);
        int  k = 0;
        bit  stop = 0;
        dual = int'(dual_hi);
        flag = 0;
        cfg_sw = sw; cfg_n = 11'(n); cfg_a = 7'(a);
        while (!stop) begin
            k++;
            ld_fb    = do_ld && (k == 1);
            save     = (k >= ss) && (k < ss + sl);
            vco_tick = ((k % div) == 0);
            @(negedge clk);
            if (k == 1) flag = int'(ratio_clamped);
            if (fp_pulse) stop = 1;
            else dual += int'(dual_hi);
            if (k > WD) stop = 1;
        end
        ld_fb = 0; save = 0; vco_tick = 1;
        len = k;
    endtask

    task automatic run_fr(input bit do_ld, input int r, input int ss, input int sl,
                          output int len, output int flag);
        int k = 0;
        bit stop = 0;
        flag = 0;
        cfg_r = 14'(r);
        while (!stop) begin
            k++;
            ld_ref = do_ld && (k == 1);
            save   = (k >= ss) && (k < ss + sl);
            @(negedge clk);
            if (k == 1) flag = int'(ratio_clamped);
            if (fr_pulse || k > WD) stop = 1;
        end
        ld_ref = 0; save = 0;
        len = k;
    endtask

    task automatic t_reset();
        int ffp = 0, ffr = 0;
        rst = 1;
        repeat (4) begin
            @(negedge clk);
            check("R10 reset outputs", int'({fp_pulse, fr_pulse, dual_hi, ratio_clamped}), 0);
        end
        rst = 0;
        for (int k = 1; k <= 400; k++) begin
            @(negedge clk);
            if (fr_pulse && ffr == 0) ffr = k;
            if (fp_pulse) begin ffp = k; break; end
        end
        check("R10 first fr", ffr, 10);
        check("R10 first fp", ffp, 128);
    endtask

    task automatic t_ratio();
        int l, d, f;
        run_fp(1, 1, 10, 3, 0, 0, 1, l, d, f);
        check("R5 old ratio kept", l, 128);
        check("R7 legal load no flag", f, 0);
        run_fp(0, 1, 0, 0, 0, 0, 1, l, d, f);
        check("R1 ratio 16*10+3", l, 163);
        check("R3 plus-one cycles 3*17", d, 51);
    endtask

    task automatic t_sw0();
        int l, d, f;
        run_fp(1, 0, 5, 4, 0, 0, 1, l, d, f);
        check("R5 old ratio kept", l, 163);
        run_fp(0, 0, 0, 0, 0, 0, 1, l, d, f);
        check("R2 ratio 32*5+4", l, 164);
        check("R3 plus-one cycles 4*33", d, 132);
    endtask

    task automatic t_clamp_n();
        int l, d, f;
        run_fp(1, 1, 3, 2, 0, 0, 1, l, d, f);
        check("R7 flag on N<5", f, 1);
        run_fp(0, 1, 0, 0, 0, 0, 1, l, d, f);
        check("R7 N clamped 16*5+2", l, 82);
        check("R3 plus-one cycles 2*17", d, 34);
    endtask

    task automatic t_clamp_a();
        int l, d, f;
        run_fp(1, 1, 6, 9, 0, 0, 1, l, d, f);
        check("R8 flag on A>=N", f, 1);
        check("R5 old ratio kept", l, 82);
        run_fp(0, 1, 0, 0, 0, 0, 1, l, d, f);
        check("R8 A clamped 16*6+5", l, 101);
        check("R3 plus-one cycles 5*17", d, 85);
    endtask

    task automatic t_half_rate();
        int l, d, f;
        run_fp(0, 1, 0, 0, 0, 0, 2, l, d, f);
        check("R11 half-rate ticks", l, 202);
    endtask

    task automatic t_save();
        int l, d, f;
        run_fp(0, 1, 0, 0, 20, 7, 1, l, d, f);
        check("R9 save stretches period", l, 108);
        run_fp(1, 1, 8, 0, 1, 5, 1, l, d, f);
        check("R9 load during save", l, 106);
        run_fp(0, 1, 0, 0, 0, 0, 1, l, d, f);
        check("R9 load from save applied", l, 128);
        check("R3 no plus-one with A=0", d, 0);
    endtask

    task automatic t_ref();
        int l, f;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (fr_pulse) break;
        end
        run_fr(1, 7, 0, 0, l, f);
        check("R6 old R kept", l, 10);
        run_fr(0, 0, 0, 0, l, f);
        check("R4 ratio R=7", l, 7);
        run_fr(1, 2, 0, 0, l, f);
        check("R7 flag on R<5", f, 1);
        check("R6 old R kept", l, 7);
        run_fr(0, 0, 0, 0, l, f);
        check("R7 R clamped to 5", l, 5);
        run_fr(0, 0, 2, 4, l, f);
        check("R9 save stretches fr", l, 9);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ratio();
        t_sw0();
        t_clamp_n();
        t_clamp_a();
        t_half_rate();
        t_save();
        t_ref();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule